// File: doc/BRIEF.md
# Self-Synchronizing PRBS Bit-Error Tester

This block drives a pseudorandom bit pattern out on a serial stream toward a device under test and checks the serial stream that comes back. The pattern comes from a linear feedback shift register whose polynomial is a parameter (default x^7 + x^6 + 1). The receive side needs no knowledge of the loop delay. It first loads a local reference register straight from the incoming bits. Once that register is full, the register runs on its own feedback and predicts every following bit. Each received bit is then compared with its prediction.

A second, self-consistency check runs alongside the comparison. It tests each received bit against the recurrence applied to the last received bits, because a sum of two shifted copies of the sequence is again the sequence. This check tells the two failure kinds apart:

- A real bit error breaks the self-consistency check as well as the comparison. It is counted once.
- A lost or duplicated bit leaves the received stream self-consistent while the comparison keeps failing. The block then counts one slip, throws away the errors it was holding for that event, and reloads its reference.

Both streams use valid/ready handshakes. The transmit side holds `tx_valid` high from reset onward. It keeps `tx_bit` stable and does not advance the pattern while `tx_ready` is low. The receive side never applies back-pressure: `rx_ready` is always high, and a bit is taken on every clock edge where `rx_valid` is high. A `restart` pulse clears the counters and forces a fresh load.

Top module: `prbs_bert`

## Requirements
- R1: After reset, `tx_valid` stays 1. The transmit pattern advances by one bit only on an edge where `tx_ready` is 1; otherwise `tx_bit` holds. The accepted bits x[k] obey x[k] = x[k-6] XOR x[k-7] for the default polynomial.
- R2: After reset, all three counters read 0 and `in_sync` reads 0.
- R3: Load phase. The first W accepted receive bits (W = 7 by default) fill the reference. None of them is counted. `in_sync` rises on the edge that takes the W-th bit, and the block locks to a sequence starting at any phase.
- R4: `bit_cnt` grows by one for each bit accepted while `in_sync` is 1, and only then.
- R5: An isolated inverted bit adds exactly 1 to `err_cnt` and nothing to `slip_cnt`. The error is committed once the received stream has again been self-consistent for 2W bits.
- R6: A dropped or a repeated bit adds exactly 1 to `slip_cnt` and 0 to `err_cnt`. The block then drops `in_sync`, reloads, and locks again.
- R7: Cycles with `rx_valid` = 0 have no effect on any counter or on `in_sync`, whatever `rx_bit` carries. `rx_ready` is always 1.
- R8: A `restart` pulse sets all counters to 0 on the next edge and returns the block to the load phase.
- R9: Every counter is CNT_W bits wide (48 by default) and stops at its all-ones value instead of wrapping. Between restarts no counter ever decreases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| restart | input | 1 | Clear counters and resynchronize |
| tx_bit | output | 1 | Transmit pattern bit |
| tx_valid | output | 1 | Transmit bit is valid |
| tx_ready | input | 1 | Sink accepts the transmit bit |
| rx_bit | input | 1 | Returned bit |
| rx_valid | input | 1 | Returned bit is valid |
| rx_ready | output | 1 | Always 1: the receive side never stalls |
| in_sync | output | 1 | 1 in the measure phase |
| bit_cnt | output | CNT_W | Bits checked in the measure phase |
| err_cnt | output | CNT_W | Committed bit errors |
| slip_cnt | output | CNT_W | Detected slips |

## Verification
The assertions check on every cycle that:
- the transmit bit holds under back-pressure;
- `bit_cnt` moves by at most one, and only while in sync;
- counters never fall except on restart, and restart clears them;
- a slip is always accompanied by loss of sync.

Whether a single flipped bit really lands in `err_cnt`, whether a dropped or doubled bit is classed as a slip with no leftover errors, and whether lock is reached at an arbitrary phase can only be shown by the bench's scenarios against its own model of the sequence.

// File: rtl/bert_pkg.sv
package bert_pkg;
  typedef enum logic {ST_LOAD = 1'b0, ST_MEASURE = 1'b1} sync_state_t;
endpackage

// File: rtl/bert_prbs_source.sv
module bert_prbs_source #(
  parameter int          W    = 7,
  parameter logic [W-1:0] TAPS = 7'b1100000,
  parameter logic [W-1:0] SEED = 7'b0000001
) (
  input  logic clk,
  input  logic rst_n,
  input  logic advance,
  output logic bit_out
);
  logic [W-1:0] state_q;
  logic         fb;

  assign fb      = ^(state_q & TAPS);
  assign bit_out = state_q[W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       state_q <= SEED;
    else if (advance) state_q <= {state_q[W-2:0], fb};
  end
endmodule

// File: rtl/bert_sat_counter.sv
module bert_sat_counter #(
  parameter int CW = 48,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic [AW-1:0] amount,
  output logic [CW-1:0] value
);
  localparam int SW = ((CW > AW) ? CW : AW) + 1;
  localparam logic [SW-1:0] TOP = SW'({CW{1'b1}});

  logic [SW-1:0] sum;

  assign sum = SW'(value) + SW'(amount);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   value <= '0;
    else if (clr) value <= '0;
    else if (en)  value <= (sum > TOP) ? {CW{1'b1}} : sum[CW-1:0];
  end
endmodule

// File: rtl/bert_sync_engine.sv
module bert_sync_engine
  import bert_pkg::*;
#(
  parameter int           W    = 7,
  parameter logic [W-1:0] TAPS = 7'b1100000,
  parameter int           PW   = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          rx_valid,
  input  logic          rx_bit,
  output logic          in_sync,
  output logic          bit_inc,
  output logic          err_commit,
  output logic [PW-1:0] err_amt,
  output logic          slip_hit
);
  localparam int LW  = $clog2(W + 1);
  localparam int CLW = $clog2(2 * W + 1);

  sync_state_t   state_q;
  logic [W-1:0]  ref_q, hist_q;
  logic [LW-1:0] lcnt_q;
  logic [CLW-1:0] clean_q;
  logic [PW-1:0] pend_q, pend_next;
  logic          win_q;
  logic          pred, self_pred, mis, self_ok, take, measuring;

  always_comb begin
    pred       = ^(ref_q & TAPS);
    self_pred  = ^(hist_q & TAPS);
    mis        = rx_bit ^ pred;
    self_ok    = (rx_bit == self_pred);
    take       = rx_valid && !restart;
    measuring  = (state_q == ST_MEASURE);
    slip_hit   = take && measuring && win_q && self_ok && mis && (clean_q >= CLW'(W));
    err_commit = take && measuring && win_q && self_ok && !slip_hit &&
                 (clean_q == CLW'(2 * W - 1));
    bit_inc    = take && measuring;
    err_amt    = pend_q;
    pend_next  = (pend_q == {PW{1'b1}}) ? pend_q : pend_q + PW'(mis);
  end

  assign in_sync = measuring;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_LOAD;
      ref_q   <= '1;
      hist_q  <= '1;
      lcnt_q  <= '0;
      clean_q <= '0;
      pend_q  <= '0;
      win_q   <= 1'b0;
    end else if (restart) begin
      state_q <= ST_LOAD;
      lcnt_q  <= '0;
      clean_q <= '0;
      pend_q  <= '0;
      win_q   <= 1'b0;
    end else if (rx_valid) begin
      hist_q <= {hist_q[W-2:0], rx_bit};
      if (!measuring) begin
        ref_q <= {ref_q[W-2:0], rx_bit};
        if (lcnt_q == LW'(W - 1)) begin
          lcnt_q  <= '0;
          state_q <= ST_MEASURE;
        end else begin
          lcnt_q <= lcnt_q + 1'b1;
        end
      end else begin
        ref_q <= {ref_q[W-2:0], pred};
        if (slip_hit) begin
          state_q <= ST_LOAD;
          lcnt_q  <= '0;
          win_q   <= 1'b0;
          pend_q  <= '0;
          clean_q <= '0;
        end else if (err_commit) begin
          win_q   <= 1'b0;
          pend_q  <= '0;
          clean_q <= '0;
        end else if (win_q) begin
          clean_q <= self_ok ? clean_q + 1'b1 : '0;
          pend_q  <= pend_next;
        end else if (mis) begin
          win_q   <= 1'b1;
          pend_q  <= PW'(1);
          clean_q <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/prbs_bert.sv
module prbs_bert #(
  parameter int           W     = 7,
  parameter logic [W-1:0] TAPS  = 7'b1100000,
  parameter logic [W-1:0] SEED  = 7'b0000001,
  parameter int           CNT_W = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  output logic             tx_bit,
  output logic             tx_valid,
  input  logic             tx_ready,
  input  logic             rx_bit,
  input  logic             rx_valid,
  output logic             rx_ready,
  output logic             in_sync,
  output logic [CNT_W-1:0] bit_cnt,
  output logic [CNT_W-1:0] err_cnt,
  output logic [CNT_W-1:0] slip_cnt
);
  localparam int PW   = 16;
  localparam int NCNT = 3;

  logic          bit_inc, err_commit, slip_hit, valid_q;
  logic [PW-1:0] err_amt;
  logic          cnt_en  [NCNT];
  logic [PW-1:0] cnt_amt [NCNT];
  logic [CNT_W-1:0] cnt_val [NCNT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= 1'b1;
  end

  assign tx_valid = valid_q;
  assign rx_ready = 1'b1;

  bert_prbs_source #(.W(W), .TAPS(TAPS), .SEED(SEED)) u_src (
    .clk(clk), .rst_n(rst_n), .advance(valid_q && tx_ready), .bit_out(tx_bit)
  );

  bert_sync_engine #(.W(W), .TAPS(TAPS), .PW(PW)) u_sync (
    .clk(clk), .rst_n(rst_n), .restart(restart), .rx_valid(rx_valid),
    .rx_bit(rx_bit), .in_sync(in_sync), .bit_inc(bit_inc),
    .err_commit(err_commit), .err_amt(err_amt), .slip_hit(slip_hit)
  );

  always_comb begin
    cnt_en[0] = bit_inc;    cnt_amt[0] = PW'(1);
    cnt_en[1] = err_commit; cnt_amt[1] = err_amt;
    cnt_en[2] = slip_hit;   cnt_amt[2] = PW'(1);
  end

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    bert_sat_counter #(.CW(CNT_W), .AW(PW)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr(restart), .en(cnt_en[g]),
      .amount(cnt_amt[g]), .value(cnt_val[g])
    );
  end

  assign bit_cnt  = cnt_val[0];
  assign err_cnt  = cnt_val[1];
  assign slip_cnt = cnt_val[2];
endmodule

// File: rtl/bert_checker.sv
module bert_checker #(
  parameter int CW = 48
) (
  input logic          clk,
  input logic          rst_n,
  input logic          restart,
  input logic          tx_ready,
  input logic          tx_bit,
  input logic          in_sync,
  input logic [CW-1:0] bit_cnt,
  input logic [CW-1:0] err_cnt,
  input logic [CW-1:0] slip_cnt
);
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_ready |=> $stable(tx_bit)); // R1
  AST_BITS_ONLY_IN_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_sync && !restart) |=> bit_cnt == $past(bit_cnt)); // R4
  AST_BITS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |=> (bit_cnt == $past(bit_cnt) || bit_cnt == $past(bit_cnt) + 1'b1)); // R4
  AST_ERR_NO_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |=> err_cnt >= $past(err_cnt)); // R9
  AST_SLIP_NO_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |=> slip_cnt >= $past(slip_cnt)); // R9
  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (bit_cnt == '0 && err_cnt == '0 && slip_cnt == '0 && !in_sync)); // R8
  AST_SLIP_DROPS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (slip_cnt != $past(slip_cnt)) |-> !in_sync); // R6
endmodule

bind prbs_bert bert_checker #(.CW(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .restart(restart), .tx_ready(tx_ready),
  .tx_bit(tx_bit), .in_sync(in_sync), .bit_cnt(bit_cnt),
  .err_cnt(err_cnt), .slip_cnt(slip_cnt)
);

// File: tb/tb_prbs_bert.sv
`timescale 1ns/1ps
module tb_prbs_bert;
  localparam int CW = 48;
  logic clk = 1'b0;
  logic rst_n, restart, tx_ready, rx_bit, rx_valid;
  logic tx_bit, tx_valid, rx_ready, in_sync;
  logic [CW-1:0] bit_cnt, err_cnt, slip_cnt;
  logic tx_bit_s, tx_valid_s, rx_ready_s, in_sync_s;
  logic [3:0] bit_s, err_s, slip_s;

  int checks = 0, fails = 0;
  logic [6:0] bm;
  longint exp_bits;

  always #2.5 clk = ~clk;

  prbs_bert dut (.clk(clk), .rst_n(rst_n), .restart(restart), .tx_bit(tx_bit),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_bit(rx_bit), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .in_sync(in_sync), .bit_cnt(bit_cnt), .err_cnt(err_cnt),
    .slip_cnt(slip_cnt));

  prbs_bert #(.CNT_W(4)) dut_sat (.clk(clk), .rst_n(rst_n), .restart(restart),
    .tx_bit(tx_bit_s), .tx_valid(tx_valid_s), .tx_ready(tx_ready), .rx_bit(rx_bit),
    .rx_valid(rx_valid), .rx_ready(rx_ready_s), .in_sync(in_sync_s), .bit_cnt(bit_s),
    .err_cnt(err_s), .slip_cnt(slip_s));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Model of the sequence: next = x[k-6] ^ x[k-7], bm[0] newest.
  function automatic logic model_next(input logic [6:0] h);
    return h[6] ^ h[5];
  endfunction

  task automatic drive(input logic v, input logic b);
    @(negedge clk);
    rx_valid = v;
    rx_bit   = b;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 1'($urandom % 2));
  endtask

  task automatic send_good(input int n, input bit gaps);
    for (int i = 0; i < n; i++) begin
      logic nb;
      if (gaps && ($urandom % 4 == 0)) drive(1'b0, 1'($urandom % 2));
      nb = model_next(bm);
      bm = {bm[5:0], nb};
      drive(1'b1, nb);
    end
  endtask

  initial begin
    #1000000;
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    longint b0, e0, s0;
    logic nb;
    void'($urandom(32'd5150));
    rst_n = 1'b0; restart = 1'b0; tx_ready = 1'b0; rx_valid = 1'b0; rx_bit = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bit_cnt == 0 && err_cnt == 0 && slip_cnt == 0, "R2 counters", bit_cnt + err_cnt + slip_cnt, 0);
    chk(in_sync == 1'b0, "R2 in_sync", in_sync, 0);
    chk(tx_valid == 1'b1, "R1 tx_valid", tx_valid, 1);
    chk(rx_ready == 1'b1, "R7 rx_ready", rx_ready, 1);

    // R3: lock at a random phase after exactly 7 bits
    bm = 7'($urandom % 127) + 7'd1;
    send_good(6, 1'b0);
    idle(1);
    chk(in_sync == 1'b0, "R3 not yet locked", in_sync, 0);
    send_good(1, 1'b0);
    idle(1);
    chk(in_sync == 1'b1, "R3 locked after W bits", in_sync, 1);
    chk(bit_cnt == 0, "R4 load bits not counted", bit_cnt, 0);

    // R4 clean run with random gaps
    send_good(60, 1'b1);
    idle(2);
    exp_bits = 60;
    chk(err_cnt == 0 && slip_cnt == 0, "R4 clean run no errors", err_cnt + slip_cnt, 0);
    chk(bit_cnt == exp_bits, "R4 bit count", bit_cnt, exp_bits);
    chk(bit_s == 4'hF, "R9 saturation of bit counter", bit_s, 15);

    // R7 idle cycles with toggling data
    b0 = bit_cnt; e0 = err_cnt; s0 = slip_cnt;
    idle(8);
    chk(bit_cnt == b0 && err_cnt == e0 && slip_cnt == s0 && in_sync, "R7 idle no effect", bit_cnt, b0);

    // R5 isolated flips
    for (int k = 0; k < 5; k++) begin
      send_good(45, 1'b1);
      nb = model_next(bm);
      bm = {bm[5:0], nb};
      drive(1'b1, ~nb);
    end
    send_good(45, 1'b1);
    idle(2);
    exp_bits += 45 * 6 + 5;
    chk(err_cnt == 5, "R5 isolated errors", err_cnt, 5);
    chk(slip_cnt == 0, "R5 no slip from errors", slip_cnt, 0);
    chk(bit_cnt == exp_bits, "R4 bits with errors", bit_cnt, exp_bits);
    chk(err_s == 5, "R9 small counter below limit", err_s, 5);

    // R6 dropped bit
    nb = model_next(bm);
    bm = {bm[5:0], nb};
    send_good(90, 1'b1);
    idle(2);
    chk(slip_cnt == 1, "R6 drop counted as slip", slip_cnt, 1);
    chk(err_cnt == 5, "R6 drop adds no errors", err_cnt, 5);
    chk(in_sync == 1'b1, "R6 relocked after drop", in_sync, 1);

    // R6 repeated bit
    drive(1'b1, bm[0]);
    send_good(90, 1'b1);
    idle(2);
    chk(slip_cnt == 2, "R6 repeat counted as slip", slip_cnt, 2);
    chk(err_cnt == 5, "R6 repeat adds no errors", err_cnt, 5);

    // R8 restart
    @(negedge clk); restart = 1'b1;
    @(negedge clk); restart = 1'b0;
    chk(bit_cnt == 0 && err_cnt == 0 && slip_cnt == 0, "R8 restart clears", bit_cnt + err_cnt + slip_cnt, 0);
    chk(in_sync == 1'b0, "R8 back to load", in_sync, 0);
    bm = 7'($urandom % 127) + 7'd1;
    send_good(27, 1'b1);
    idle(2);
    chk(in_sync && bit_cnt == 20 && err_cnt == 0, "R3 relock after restart", bit_cnt, 20);

    // R1 transmit recurrence and hold
    begin
      logic acc [0:399];
      int n = 0, bad = 0, holdbad = 0;
      logic prev = 1'b0, last_rdy = 1'b0;
      for (int i = 0; i < 400; i++) begin
        @(negedge clk);
        if (i > 0) begin
          if (last_rdy) begin acc[n] = prev; n++; end
          else if (tx_bit != prev) holdbad++;
        end
        prev = tx_bit;
        tx_ready = ($urandom % 3 != 0);
        last_rdy = tx_ready;
      end
      for (int k = 7; k < n; k++)
        if (acc[k] != (acc[k-6] ^ acc[k-7])) bad++;
      chk(holdbad == 0, "R1 hold when not ready", holdbad, 0);
      chk(bad == 0, "R1 transmit recurrence", bad, 0);
      chk(n > 100, "R1 transmit advances", n, 100);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule